// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block drives the active-low read and write strobes of a parallel ATA channel for PIO and multiword DMA transfers. All of its timing comes from one 32-bit configuration word. That word carries two independent timing sets: one for data-port transfers and one for task-file register transfers. Each set has three fields: a setup interval, an active-strobe length and an inactive (recovery) length. All three are counted in bus clocks.

A host sequencer raises `start` for one clock while `busy` is low. With the request it supplies a register/data select and a read/write select. At that edge the block captures the chosen timing set and the direction. It then runs the setup, active and recovery phases and reports completion with a one-clock `done` pulse. Ultra DMA burst signalling and IORDY wait handling are handled elsewhere.

Top module: `ata_strobe_gen`

## Requirements
- R1: While reset is asserted and whenever `busy` is low, `rd_n` and `wr_n` are both high. `done` is low during reset.
- R2: On a data cycle (`is_reg`=0), the selected strobe stays low for (word[8:4] + 1) clocks.
- R3: On a data cycle, the recovery phase after the active phase lasts (word[3:0] + 1) clocks, with `busy` high and both strobes high.
- R4: On a register cycle (`is_reg`=1), the active length is word[17:13] + 1 and the recovery length is word[12:9] + 1. The data fields are not used.
- R5: The setup interval, with `busy` high and both strobes high, lasts word[24:22] clocks on a data cycle and word[27:25] clocks on a register cycle. A value of zero makes the strobe go low on the clock right after acceptance.
- R6: `is_write`=1 drives only `wr_n` low, and `is_write`=0 drives only `rd_n` low. The two strobes are never low together.
- R7: `done` is high for exactly one clock, in the cycle after the last recovery clock, and `busy` is low in that cycle. A `start` raised while `busy` is high is ignored. A `start` raised in the `done` cycle is accepted.
- R8: The timing word, `is_reg` and `is_write` are captured when the request is accepted. Changing them during a cycle does not affect that cycle.
- R9: Word bits 31:28 and 21:18 have no effect on strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timing_word | input | 32 | Timing configuration word |
| start | input | 1 | Cycle request, accepted when `busy` is low |
| is_reg | input | 1 | 1 = task-file register cycle, 0 = data-port cycle |
| is_write | input | 1 | 1 = write strobe, 0 = read strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The completion pulse of one cycle and the acceptance of the next request can fall in the same clock. The bench provokes this by issuing its next request as soon as it sees `busy` low, which is the `done` cycle itself. The scoreboard then requires a `done` pulse on that clock, with `busy` low, followed on the very next clock by the new setup or active phase. Its measured lengths must match those computed from the newly captured word. The bench also changes the word and both selects straight after every acceptance, and pulses `start` while `busy` is high. Both actions must leave the measured cycle unchanged.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
  localparam int WORD_W   = 32;
  localparam int SET_W    = 3;
  localparam int ACT_W    = 5;
  localparam int REC_W    = 4;
  localparam int CNT_W    = (ACT_W > REC_W) ? ACT_W : REC_W;
  // field positions decoded from the word
  localparam int DREC_LSB = 0;
  localparam int DACT_LSB = 4;
  localparam int RREC_LSB = 9;
  localparam int RACT_LSB = 13;
  localparam int DSET_LSB = 22;
  localparam int RSET_LSB = 25;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] act_m1;
    logic [CNT_W-1:0] rec_m1;
  } cyc_timing_t;

  function automatic logic [SET_W-1:0] get_setup(input logic [WORD_W-1:0] w, input logic reg_sel);
    return reg_sel ? w[RSET_LSB +: SET_W] : w[DSET_LSB +: SET_W];
  endfunction

  function automatic logic [ACT_W-1:0] get_active(input logic [WORD_W-1:0] w, input logic reg_sel);
    return reg_sel ? w[RACT_LSB +: ACT_W] : w[DACT_LSB +: ACT_W];
  endfunction

  function automatic logic [REC_W-1:0] get_recover(input logic [WORD_W-1:0] w, input logic reg_sel);
    return reg_sel ? w[RREC_LSB +: REC_W] : w[DREC_LSB +: REC_W];
  endfunction

  function automatic cyc_timing_t pick_timing(input logic [WORD_W-1:0] w, input logic reg_sel);
    cyc_timing_t t;
    t.setup  = CNT_W'(get_setup(w, reg_sel));
    t.act_m1 = CNT_W'(get_active(w, reg_sel));
    t.rec_m1 = CNT_W'(get_recover(w, reg_sel));
    return t;
  endfunction
endpackage

// File: rtl/ata_timing_sel.sv
module ata_timing_sel
  import ata_strobe_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              reg_sel,
  output cyc_timing_t       tsel
);
  // enable bits and the burst clock field belong to other logic
  logic unused_bits;
  assign unused_bits = ^{word[WORD_W-1:28], word[21:18]};

  assign tsel = pick_timing(word, reg_sel);
endmodule

// File: rtl/ata_phase_seq.sv
module ata_phase_seq
  import ata_strobe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_write,
  input  cyc_timing_t tsel,
  output phase_e      phase,
  output logic        dir_wr,
  output logic        done,
  output logic        accept_ev
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_l;
  logic [CNT_W-1:0] rec_l;
  logic             cnt_zero;

  assign accept_ev = start && (phase == PH_IDLE);
  assign cnt_zero  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      act_l  <= '0;
      rec_l  <= '0;
      dir_wr <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept_ev) begin
            act_l  <= tsel.act_m1;
            rec_l  <= tsel.rec_m1;
            dir_wr <= is_write;
            if (tsel.setup != '0) begin
              phase <= PH_SETUP;
              cnt   <= tsel.setup - CNT_W'(1);
            end else begin
              phase <= PH_ACTIVE;
              cnt   <= tsel.act_m1;
            end
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            phase <= PH_ACTIVE;
            cnt   <= act_l;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_ACTIVE: begin
          if (cnt_zero) begin
            phase <= PH_RECOVER;
            cnt   <= rec_l;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_RECOVER: begin
          if (cnt_zero) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_strobe_drv.sv
module ata_strobe_drv
  import ata_strobe_pkg::*;
(
  input  phase_e phase,
  input  logic   dir_wr,
  output logic   rd_n,
  output logic   wr_n,
  output logic   busy
);
  logic strobe_on;
  assign strobe_on = (phase == PH_ACTIVE);
  assign rd_n      = !(strobe_on && !dir_wr);
  assign wr_n      = !(strobe_on && dir_wr);
  assign busy      = (phase != PH_IDLE);
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
  import ata_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] timing_word,
  input  logic              start,
  input  logic              is_reg,
  input  logic              is_write,
  output logic              rd_n,
  output logic              wr_n,
  output logic              busy,
  output logic              done
);
  cyc_timing_t tsel;
  phase_e      phase;
  logic        dir_wr;
  logic        accept_ev;

  ata_timing_sel u_sel (
    .word    (timing_word),
    .reg_sel (is_reg),
    .tsel    (tsel)
  );

  ata_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_write  (is_write),
    .tsel      (tsel),
    .phase     (phase),
    .dir_wr    (dir_wr),
    .done      (done),
    .accept_ev (accept_ev)
  );

  ata_strobe_drv u_drv (
    .phase  (phase),
    .dir_wr (dir_wr),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .busy   (busy)
  );
endmodule

// File: rtl/ata_strobe_chk.sv
module ata_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic rd_n,
  input logic wr_n,
  input logic busy,
  input logic done
);
  // R6: never both strobes low
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R1: strobes high whenever idle
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_n && wr_n));

  // R7: done lasts one clock
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done only just after a busy cycle, with busy low
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7: a cycle begins only from a request
  a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind ata_strobe_gen ata_strobe_chk i_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .rd_n  (rd_n),
  .wr_n  (wr_n),
  .busy  (busy),
  .done  (done)
);

// File: tb/test_ata_strobe_gen.sv
module test_ata_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] timing_word = '0;
  logic        start = 1'b0;
  logic        is_reg = 1'b0;
  logic        is_write = 1'b0;
  logic        rd_n, wr_n, busy, done;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int    s;
    int    a;
    int    r;
    bit    wr;
    bit    rg;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  ata_strobe_gen i_ata_strobe_gen (
    .clk(clk), .rst_n(rst_n), .timing_word(timing_word), .start(start),
    .is_reg(is_reg), .is_write(is_write), .rd_n(rd_n), .wr_n(wr_n),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp, input string note);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, note, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int ds, input int da, input int di,
                                     input int rs, input int ra, input int ri,
                                     input logic [31:0] extra);
    logic [31:0] w;
    w = extra & 32'hF03C_0000;
    w = w | (32'(di) & 32'hF);
    w = w | ((32'(da) & 32'h1F) << 4);
    w = w | ((32'(ri) & 32'hF) << 9);
    w = w | ((32'(ra) & 32'h1F) << 13);
    w = w | ((32'(ds) & 32'h7) << 22);
    w = w | ((32'(rs) & 32'h7) << 25);
    return w;
  endfunction

  // driver: called at a negedge
  task automatic drive(input logic [31:0] w, input bit rg, input bit wrt,
                       input bit poke, input string tag);
    exp_t e;
    while (busy) @(negedge clk);
    timing_word = w;
    is_reg = rg;
    is_write = wrt;
    start = 1'b1;
    e.s  = rg ? int'((w >> 25) & 7) : int'((w >> 22) & 7);
    e.a  = (rg ? int'((w >> 13) & 31) : int'((w >> 4) & 31)) + 1;
    e.r  = (rg ? int'((w >> 9) & 15) : int'(w & 15)) + 1;
    e.wr = wrt;
    e.rg = rg;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    // R8: disturb inputs right after acceptance
    timing_word = ~w;
    is_reg = ~rg;
    is_write = ~wrt;
    if (poke) begin
      // R7: request while busy must be ignored
      start = busy;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // monitor / scoreboard
  int  s_cnt, a_cnt, r_cnt;
  bit  in_cyc, saw_wr, saw_rd;
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (!rd_n && !wr_n) chk("R6", 1, 0, "both strobes low");
      if (busy) begin
        if (!in_cyc) begin
          in_cyc = 1; s_cnt = 0; a_cnt = 0; r_cnt = 0; saw_wr = 0; saw_rd = 0;
        end
        if (done) chk("R7", 1, 0, "done while busy");
        if (!rd_n || !wr_n) begin
          a_cnt++;
          if (!wr_n) saw_wr = 1;
          if (!rd_n) saw_rd = 1;
        end else if (a_cnt == 0) s_cnt++;
        else r_cnt++;
      end else begin
        if (!rd_n || !wr_n) chk("R1", 1, 0, "strobe low while idle");
        if (in_cyc) begin
          in_cyc = 0;
          if (q.size() == 0) chk("R7", 1, 0, "unexpected cycle");
          else begin
            exp_t e;
            e = q.pop_front();
            chk("R5", s_cnt, e.s, {"setup ", e.tag});
            chk(e.rg ? "R4" : "R2", a_cnt, e.a, {"active ", e.tag});
            chk(e.rg ? "R4" : "R3", r_cnt, e.r, {"recovery ", e.tag});
            chk("R6", int'(saw_wr), int'(e.wr), {"write strobe ", e.tag});
            chk("R6", int'(saw_rd), int'(!e.wr), {"read strobe ", e.tag});
            chk("R7", int'(done), 1, {"done pulse ", e.tag});
          end
        end else if (done) chk("R7", 1, 0, "stray done");
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(rd_n), 1, "rd_n in reset");
    chk("R1", int'(wr_n), 1, "wr_n in reset");
    chk("R1", int'(busy), 0, "busy in reset");
    chk("R1", int'(done), 0, "done in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(rd_n & wr_n), 1, "strobes idle after reset");

    drive(mk(0, 0, 0, 3, 3, 3, '0), 0, 0, 0, "R5 zero setup min data read");
    drive(mk(2, 3, 1, 6, 9, 7, '0), 0, 1, 0, "R2 data write");
    drive(mk(4, 2, 2, 5, 7, 2, '0), 1, 0, 0, "R4 register read");
    drive(mk(1, 1, 1, 0, 31, 15, '0), 1, 1, 0, "R4 register write max");
    drive(mk(7, 31, 15, 1, 1, 1, '0), 0, 0, 0, "R3 data read max");
    drive(mk(2, 3, 1, 6, 9, 7, 32'hF03C_0000), 0, 1, 0, "R9 extra bits set");
    drive(mk(3, 4, 5, 2, 2, 2, 32'hA014_0000), 1, 0, 0, "R9 register extra bits");
    drive(mk(0, 1, 0, 0, 1, 0, '0), 0, 1, 1, "R7 start while busy");
    drive(mk(1, 2, 3, 4, 5, 6, '0), 1, 1, 1, "R8 inputs changed in cycle");
    drive(mk(0, 0, 1, 0, 0, 0, '0), 1, 0, 0, "R7 back to back reg");
    drive(mk(0, 2, 0, 0, 0, 0, '0), 0, 1, 0, "R7 back to back data");

    for (int i = 0; i < 40 && (busy || q.size() != 0); i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R7", q.size(), 0, "pending cycles at end");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule